// File: doc/BRIEF.md
# Memory Operation Ordering Queue

This block sits between dispatch and the memory pipelines of an out-of-order core. It keeps every in-flight memory operation in program order and decides, cycle by cycle, which one may be issued. Dispatch presents one entry per cycle, classed as a load, a store, a load fence, a store fence or a full fence. Loads and load fences are charged to a load budget. Stores and store fences are charged to a store budget. A full fence is charged to both. Two full flags tell dispatch when to stall.

Each cycle the queue grants issue to at most one load or store, the oldest one that the ordering rules allow. A configuration input, `assume_disjoint`, declares that loads never overlap older stores. When it is set, loads may overtake stores that have not issued yet. Stores never overtake older loads or stores. Fences are never issued. A fence leaves the queue on its own once it is the oldest entry, which means every older operation has completed. The execution side reports each completion by tag. Entries leave from the oldest end, one per cycle, and only then return their budget.

Top module: `mem_order_queue`

## Requirements
- R1: After reset both full flags are low, no grant is presented and the next allocation tag is 0.
- R2: Kind codes on `alloc_kind` are 0 load, 1 store, 2 load fence, 3 store fence and 4 full fence. Codes 0 and 2 take one load slot, codes 1 and 3 take one store slot, and code 4 takes one of each. A full flag rises once its budget is used up. An allocation that needs a full budget is dropped, and the allocation tag does not advance.
- R3: A budget parameter of zero selects the matching default budget.
- R4: Stores are granted in program order. A store is never granted while an older store is still ungranted.
- R5: A store is never granted while an older load is still ungranted, whatever `assume_disjoint` holds.
- R6: An older load that has been granted but has not completed does not hold back a younger load, so unblocked loads are granted on consecutive cycles.
- R7: A load may be granted ahead of an older ungranted store only while `assume_disjoint` is 1. While it is 0 the load waits until that store has been granted.
- R8: A load fence or full fence holds back every younger load, and a store fence or full fence holds back every younger store, until the fence has left the queue. A store fence does not hold back loads.
- R9: A fence leaves the queue only once it is the oldest entry, that is, after every older operation has completed.
- R10: At most one grant per cycle. Among the eligible entries the oldest is granted, and `issue_tag` equals the `alloc_tag` shown when that entry was allocated.
- R11: A completion releases budget only in program order. A completed entry frees its slot once every older entry has left, so a completion reported out of order keeps its full flag high until the older entries also complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| assume_disjoint | input | 1 | 1: loads may overtake ungranted older stores |
| alloc_valid | input | 1 | Dispatch presents an entry |
| alloc_kind | input | 3 | Entry kind code (see R2) |
| alloc_tag | output | TAG_W | Tag the presented entry will receive |
| ld_full | output | 1 | Load budget exhausted |
| st_full | output | 1 | Store budget exhausted |
| issue_valid | output | 1 | Registered grant strobe |
| issue_tag | output | TAG_W | Tag of the granted entry |
| done_valid | input | 1 | Execution completion strobe |
| done_tag | input | TAG_W | Tag of the completed entry |

## Verification
The main function is tried with mixed streams in which an older load stays granted but not completed, so that a fence ahead of younger operations cannot leave. The resulting grant order then shows which rule holds back which entry. The same load, store fence, store, load stream is run with the no-overlap input at 1 and at 0, and the two cases are told apart by whether the final load is granted before the store. Further streams place a load fence, a full fence, or two equally ready loads behind a pending operation. These separate a fence that blocks too little from a fence that blocks too much, and oldest-first selection from youngest-first selection. A table of allocation kinds fills both budgets. It checks the full flags and the drop of an over-budget allocation with one budget given as zero. Completions reported out of order show whether budget is released in program order.

// File: rtl/mem_order_pkg.sv
package mem_order_pkg;

  typedef enum logic [2:0] {
    MK_LOAD  = 3'd0,
    MK_STORE = 3'd1,
    MK_LFNC  = 3'd2,
    MK_SFNC  = 3'd3,
    MK_FFNC  = 3'd4
  } mem_kind_e;

  function automatic logic takes_ld(logic [2:0] k);
    return (k == MK_LOAD) || (k == MK_LFNC) || (k == MK_FFNC);
  endfunction

  function automatic logic takes_st(logic [2:0] k);
    return (k == MK_STORE) || (k == MK_SFNC) || (k == MK_FFNC);
  endfunction

  function automatic logic is_fence(logic [2:0] k);
    return (k == MK_LFNC) || (k == MK_SFNC) || (k == MK_FFNC);
  endfunction

endpackage

// File: rtl/mem_budget.sv
module mem_budget #(
  parameter int CAP   = 4,
  localparam int CNT_W = $clog2(CAP + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic take,
  input  logic give,
  output logic full
);

  logic [CNT_W-1:0] used_q;

  always_ff @(posedge clk) begin
    if (rst) used_q <= '0;
    else if (take && !give) used_q <= used_q + 1'b1;
    else if (give && !take) used_q <= used_q - 1'b1;
  end

  assign full = (used_q == CNT_W'(CAP));

  // R2: budget never exceeds its capacity
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
    used_q <= CNT_W'(CAP));

  // R11: nothing is released from an empty budget
  a_r11_no_underflow: assert property (@(posedge clk) disable iff (rst)
    (give && !take) |-> (used_q != '0));

endmodule

// File: rtl/mem_age_pick.sv
module mem_age_pick
  import mem_order_pkg::*;
#(
  parameter int SLOTS = 8,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic [IDX_W-1:0]      oldest,
  input  logic [SLOTS-1:0]      live,
  input  logic [SLOTS-1:0]      granted,
  input  logic [SLOTS-1:0][2:0] kinds,
  input  logic                  disjoint,
  output logic                  pick,
  output logic [IDX_W-1:0]      pick_idx
);

  logic             ld_hold, st_hold;
  logic [IDX_W-1:0] s;
  logic [2:0]       k;

  // Walk from the oldest slot towards the youngest, accumulating holds.
  always_comb begin
    ld_hold  = 1'b0;
    st_hold  = 1'b0;
    pick     = 1'b0;
    pick_idx = '0;
    s        = '0;
    k        = '0;
    for (int a = 0; a < SLOTS; a++) begin
      s = oldest + IDX_W'(a);
      k = kinds[s];
      if (live[s]) begin
        if (!granted[s] && !pick &&
            (((k == MK_LOAD) && !ld_hold) || ((k == MK_STORE) && !st_hold))) begin
          pick     = 1'b1;
          pick_idx = s;
        end
        case (k)
          MK_LOAD:  if (!granted[s]) st_hold = 1'b1;
          MK_STORE: if (!granted[s]) begin
                      st_hold = 1'b1;
                      if (!disjoint) ld_hold = 1'b1;
                    end
          MK_LFNC:  ld_hold = 1'b1;
          MK_SFNC:  st_hold = 1'b1;
          MK_FFNC:  begin ld_hold = 1'b1; st_hold = 1'b1; end
          default:  ;
        endcase
      end
    end
  end

endmodule

// File: rtl/mem_order_queue.sv
module mem_order_queue
  import mem_order_pkg::*;
#(
  parameter int LQ_SIZE    = 8,
  parameter int SQ_SIZE    = 8,
  parameter int LQ_DEFAULT = 4,
  parameter int SQ_DEFAULT = 4,
  localparam int LQ_CAP = (LQ_SIZE == 0) ? LQ_DEFAULT : LQ_SIZE,
  localparam int SQ_CAP = (SQ_SIZE == 0) ? SQ_DEFAULT : SQ_SIZE,
  localparam int TAG_W  = $clog2(LQ_CAP + SQ_CAP)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             assume_disjoint,
  input  logic             alloc_valid,
  input  logic [2:0]       alloc_kind,
  output logic [TAG_W-1:0] alloc_tag,
  output logic             ld_full,
  output logic             st_full,
  output logic             issue_valid,
  output logic [TAG_W-1:0] issue_tag,
  input  logic             done_valid,
  input  logic [TAG_W-1:0] done_tag
);

  localparam int SLOTS = 1 << TAG_W;

  logic [SLOTS-1:0][2:0] kind_q;
  logic [SLOTS-1:0]      live_q, granted_q, done_q;
  logic [TAG_W-1:0]      head_q, tail_q;
  logic                  accept_w, retire_w, pick_w;
  logic [TAG_W-1:0]      pick_idx_w;
  logic [2:0]            head_kind;

  assign head_kind = kind_q[head_q];
  assign accept_w  = alloc_valid && (alloc_kind <= 3'd4)
                   && !(takes_ld(alloc_kind) && ld_full)
                   && !(takes_st(alloc_kind) && st_full);
  assign retire_w  = live_q[head_q] && (done_q[head_q] || is_fence(head_kind));
  assign alloc_tag = tail_q;

  mem_budget #(.CAP(LQ_CAP)) i_ld_budget (
    .clk(clk), .rst(rst),
    .take(accept_w && takes_ld(alloc_kind)),
    .give(retire_w && takes_ld(head_kind)),
    .full(ld_full));

  mem_budget #(.CAP(SQ_CAP)) i_st_budget (
    .clk(clk), .rst(rst),
    .take(accept_w && takes_st(alloc_kind)),
    .give(retire_w && takes_st(head_kind)),
    .full(st_full));

  mem_age_pick #(.SLOTS(SLOTS)) i_pick (
    .oldest(head_q), .live(live_q), .granted(granted_q), .kinds(kind_q),
    .disjoint(assume_disjoint), .pick(pick_w), .pick_idx(pick_idx_w));

  // Kind storage carries no reset so it maps onto plain memory.
  always_ff @(posedge clk) begin
    if (accept_w) kind_q[tail_q] <= alloc_kind;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q      <= '0;
      granted_q   <= '0;
      done_q      <= '0;
      head_q      <= '0;
      tail_q      <= '0;
      issue_valid <= 1'b0;
      issue_tag   <= '0;
    end else begin
      if (accept_w) begin
        live_q[tail_q]    <= 1'b1;
        granted_q[tail_q] <= 1'b0;
        done_q[tail_q]    <= 1'b0;
        tail_q            <= tail_q + 1'b1;
      end
      if (retire_w) begin
        live_q[head_q] <= 1'b0;
        head_q         <= head_q + 1'b1;
      end
      if (pick_w) granted_q[pick_idx_w] <= 1'b1;
      if (done_valid && live_q[done_tag] && granted_q[done_tag])
        done_q[done_tag] <= 1'b1;
      issue_valid <= pick_w;
      issue_tag   <= pick_idx_w;
    end
  end

  // R2: a load-class allocation against a full load budget leaves the tag alone
  a_r2_drop_when_full: assert property (@(posedge clk) disable iff (rst)
    (alloc_valid && ld_full && takes_ld(alloc_kind)) |=> (tail_q == $past(tail_q)));

  // R11: the load budget opens only after an in-order departure
  a_r11_release_in_order: assert property (@(posedge clk) disable iff (rst)
    $fell(ld_full) |-> $past(retire_w));

  // R10: a grant always names an entry that is still in the queue
  a_r10_grant_live: assert property (@(posedge clk) disable iff (rst)
    issue_valid |-> live_q[issue_tag]);

endmodule

// File: tb/test_mem_order_queue.sv
module test_mem_order_queue;

  localparam int TAG_W = 3;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             assume_disjoint = 1'b1;
  logic             alloc_valid = 1'b0;
  logic [2:0]       alloc_kind = 3'd0;
  logic [TAG_W-1:0] alloc_tag;
  logic             ld_full, st_full, issue_valid;
  logic [TAG_W-1:0] issue_tag;
  logic             done_valid = 1'b0;
  logic [TAG_W-1:0] done_tag = '0;

  int n_chk = 0;
  int n_bad = 0;
  int log_n = 0;
  logic [TAG_W-1:0] glog [32];

  always #5 clk = ~clk;

  mem_order_queue #(.LQ_SIZE(0), .SQ_SIZE(4), .LQ_DEFAULT(4), .SQ_DEFAULT(8)) i_mem_order_queue (
    .clk(clk), .rst(rst), .assume_disjoint(assume_disjoint),
    .alloc_valid(alloc_valid), .alloc_kind(alloc_kind), .alloc_tag(alloc_tag),
    .ld_full(ld_full), .st_full(st_full),
    .issue_valid(issue_valid), .issue_tag(issue_tag),
    .done_valid(done_valid), .done_tag(done_tag));

  // grant recorder, sampled just after each rising edge
  always @(posedge clk) begin
    #2;
    if (issue_valid && log_n < 32) begin
      glog[log_n] = issue_tag;
      log_n++;
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic dis);
    @(negedge clk);
    rst = 1'b1;
    assume_disjoint = dis;
    idle(2);
    rst = 1'b0;
    log_n = 0;
  endtask

  task automatic put(input logic [2:0] k);
    alloc_valid = 1'b1;
    alloc_kind  = k;
    @(negedge clk);
    alloc_valid = 1'b0;
  endtask

  task automatic finish_op(input logic [TAG_W-1:0] t);
    done_valid = 1'b1;
    done_tag   = t;
    @(negedge clk);
    done_valid = 1'b0;
  endtask

  // kind, expected ld_full, expected st_full after the allocation
  localparam logic [4:0] VEC [8] = '{
    {3'd0, 1'b0, 1'b0},
    {3'd0, 1'b0, 1'b0},
    {3'd4, 1'b0, 1'b0},
    {3'd3, 1'b0, 1'b0},
    {3'd1, 1'b0, 1'b0},
    {3'd2, 1'b1, 1'b0},
    {3'd1, 1'b1, 1'b1},
    {3'd0, 1'b1, 1'b1}
  };

  initial begin
    #(200000 * 10);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    do_reset(1'b1);
    // R1 reset state
    chk(!ld_full, "R1 ld_full", ld_full, 0);
    chk(!st_full, "R1 st_full", st_full, 0);
    chk(!issue_valid, "R1 issue_valid", issue_valid, 0);
    chk(alloc_tag == 0, "R1 alloc_tag", alloc_tag, 0);

    // R2 / R3 budget table, load budget given as zero -> default of 4
    for (int v = 0; v < 8; v++) begin
      put(VEC[v][4:2]);
      chk(ld_full == VEC[v][1], "R2_R3 ld_full", ld_full, VEC[v][1]);
      chk(st_full == VEC[v][0], "R2 st_full", st_full, VEC[v][0]);
    end
    chk(alloc_tag == 7, "R2 dropped alloc keeps tag", alloc_tag, 7);

    // R6: loads granted back to back without completion
    do_reset(1'b1);
    put(3'd0); put(3'd0); put(3'd0);
    idle(3);
    chk(log_n == 3, "R6 load count", log_n, 3);
    chk(glog[0] == 0 && glog[1] == 1 && glog[2] == 2, "R6 load order", glog[2], 2);

    // R7 with overlap assumed absent; R8 store fence passes loads, holds stores
    do_reset(1'b1);
    put(3'd0); put(3'd3); put(3'd1); put(3'd0);
    idle(4);
    chk(log_n == 2, "R8 store held by store fence", log_n, 2);
    chk(glog[1] == 3, "R7 load passes store", glog[1], 3);
    finish_op(3'd0);
    idle(5);
    chk(log_n == 3 && glog[2] == 2, "R9 fence leaves after completion", glog[2], 2);

    // R7 with overlap possible
    do_reset(1'b0);
    put(3'd0); put(3'd3); put(3'd1); put(3'd0);
    idle(4);
    chk(log_n == 1, "R7 load waits for store", log_n, 1);
    finish_op(3'd0);
    idle(6);
    chk(log_n == 3 && glog[1] == 2 && glog[2] == 3, "R7 store then load", glog[1], 2);

    // R5 and R8 load fence: store behind an ungranted load
    do_reset(1'b1);
    put(3'd0); put(3'd2); put(3'd0); put(3'd1);
    idle(4);
    chk(log_n == 1, "R5_R8 store and load held", log_n, 1);
    finish_op(3'd0);
    idle(6);
    chk(log_n == 3 && glog[1] == 2 && glog[2] == 3, "R5 load before store", glog[2], 3);

    // R10 oldest of two ready loads first
    do_reset(1'b1);
    put(3'd0); put(3'd2); put(3'd0); put(3'd0);
    idle(3);
    finish_op(3'd0);
    idle(6);
    chk(log_n == 3 && glog[1] == 2 && glog[2] == 3, "R10 oldest first", glog[1], 2);

    // R8 full fence holds both
    do_reset(1'b1);
    put(3'd0); put(3'd4); put(3'd0); put(3'd1);
    idle(4);
    chk(log_n == 1, "R8 full fence", log_n, 1);
    finish_op(3'd0);
    idle(6);
    chk(log_n == 3, "R8 full fence release", log_n, 3);

    // R4 stores in program order
    do_reset(1'b1);
    put(3'd1); put(3'd1); put(3'd1);
    idle(3);
    chk(log_n == 3 && glog[0] == 0 && glog[1] == 1 && glog[2] == 2, "R4 store order", glog[1], 1);

    // R11 in-order release
    do_reset(1'b1);
    put(3'd0); put(3'd0); put(3'd0); put(3'd0);
    idle(2);
    chk(ld_full, "R11 full after four loads", ld_full, 1);
    finish_op(3'd1);
    idle(3);
    chk(ld_full, "R11 out-of-order completion holds", ld_full, 1);
    finish_op(3'd0);
    idle(3);
    chk(!ld_full, "R11 release after oldest completes", ld_full, 0);
    chk(alloc_tag == 4, "R11 next tag", alloc_tag, 4);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule